// File: doc/BRIEF.md
# Character Raster Timing Generator

This block produces the sweep timing for a character-cell display. A free-running column counter steps once per character clock. At the end of each line, a scan-line counter advances inside the current character row. When a row is finished, a row counter advances. After the last row, an optional run of extra scan lines lets the frame height be trimmed to a whole number of lines that is not a multiple of the row height.

Horizontal sync, vertical sync, display enable and vertical blank are decoded from these counters and from a set of configuration inputs. The configuration inputs are expected to be held by a surrounding register bank. Column, row and scan line are also brought out for the fetch and pixel logic downstream.

Configuration is sampled continuously. It should only be changed while reset is held or at the point where a frame wraps.

Top module: `crt_raster_timer`

## Requirements
- R1: `col` counts 0, 1, … up to `cfg_htotal` and then returns to 0. A line therefore lasts `cfg_htotal`+1 character clocks.
- R2: `hsync` is high while `cfg_hsync_at` ≤ `col` < `cfg_hsync_at` + `cfg_sync_w[3:0]`. When `cfg_sync_w[3:0]` is 0, no pulse is produced.
- R3: Within a character row, `scan` counts 0 up to `cfg_scan_max` and advances at each line end, so a row has `cfg_scan_max`+1 lines. When a row is finished, `row` increments and `scan` returns to 0.
- R4: `row` counts 0 up to `cfg_vtotal`. When no extra lines are programmed (`cfg_vadjust` = 0), the frame wraps to row 0, scan 0 after the last line of row `cfg_vtotal`.
- R5: When `cfg_vadjust` is nonzero, `cfg_vadjust` extra lines follow the last line of row `cfg_vtotal`. During these lines `row` holds `cfg_vtotal` and `scan` counts 0 up to `cfg_vadjust`−1. The frame then wraps to row 0, scan 0.
- R6: `vsync` rises at column 0 of scan line 0 of row `cfg_vsync_at`, outside the extra lines. It stays high for W whole lines, where W is `cfg_sync_w[7:4]` and a field value of 0 means 16.
- R7: `disp_en` is high exactly when `col` < `cfg_hdisp` and `row` < `cfg_vdisp` and the extra lines are not in progress.
- R8: `vblank` is high exactly when `row` ≥ `cfg_vdisp` or the extra lines are in progress.
- R9: While `rst_n` is low, `col`, `row` and `scan` are 0 and `vsync` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | character clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_htotal | input | CW | characters per line minus one |
| cfg_hdisp | input | CW | displayed characters per line |
| cfg_hsync_at | input | CW | column where horizontal sync starts |
| cfg_sync_w | input | 8 | [7:4] vertical sync lines (0 = 16), [3:0] horizontal sync characters |
| cfg_vtotal | input | RW | character rows per frame minus one |
| cfg_vadjust | input | SW | extra scan lines after the last row |
| cfg_vdisp | input | RW | displayed character rows |
| cfg_vsync_at | input | RW | row where vertical sync starts |
| cfg_scan_max | input | SW | scan lines per row minus one |
| col | output | CW | current character column |
| row | output | RW | current character row |
| scan | output | SW | current scan line (extra-line index during the extra lines) |
| hsync | output | 1 | horizontal sync |
| vsync | output | 1 | vertical sync |
| disp_en | output | 1 | display enable |
| vblank | output | 1 | vertical blank |

## Verification
The counters update on the clock edge. Every decoded output is a direct function of the updated counters, so each result belongs to the same cycle as the counter state it describes. Vertical sync is the exception in mechanism only: its line counter updates at the same edge as the line advance, so it is also due in that cycle.

The bench steps a model of its own once per rising edge. It compares every output at the following falling edge, which is half a cycle after the edge that produced the value.

// File: rtl/crt_raster_timer.sv
module crt_raster_timer #(
  parameter int CW = 8,
  parameter int RW = 8,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_htotal,
  input  logic [CW-1:0] cfg_hdisp,
  input  logic [CW-1:0] cfg_hsync_at,
  input  logic [7:0]    cfg_sync_w,
  input  logic [RW-1:0] cfg_vtotal,
  input  logic [SW-1:0] cfg_vadjust,
  input  logic [RW-1:0] cfg_vdisp,
  input  logic [RW-1:0] cfg_vsync_at,
  input  logic [SW-1:0] cfg_scan_max,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic [SW-1:0] scan,
  output logic          hsync,
  output logic          vsync,
  output logic          disp_en,
  output logic          vblank
);
  logic          in_adj, n_adj;
  logic [RW-1:0] n_row;
  logic [SW-1:0] n_scan;
  logic [4:0]    vs_cnt, vs_w;
  logic [CW:0]   hs_end;

  wire line_end = (col >= cfg_htotal);
  wire adj_last = ({1'b0, scan} + 1'b1) >= {1'b0, cfg_vadjust};

  assign vs_w   = (cfg_sync_w[7:4] == 4'd0) ? 5'd16 : {1'b0, cfg_sync_w[7:4]};
  assign hs_end = {1'b0, cfg_hsync_at} + (CW+1)'(cfg_sync_w[3:0]);

  always_comb begin
    n_row  = row;
    n_scan = scan;
    n_adj  = in_adj;
    if (in_adj) begin
      if (adj_last) begin
        n_row = '0; n_scan = '0; n_adj = 1'b0;
      end else n_scan = scan + 1'b1;
    end else if (scan >= cfg_scan_max) begin
      n_scan = '0;
      if (row >= cfg_vtotal) begin
        if (cfg_vadjust == '0) n_row = '0;
        else n_adj = 1'b1;
      end else n_row = row + 1'b1;
    end else n_scan = scan + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col    <= '0;
      row    <= '0;
      scan   <= '0;
      in_adj <= 1'b0;
      vs_cnt <= '0;
    end else if (line_end) begin
      col    <= '0;
      row    <= n_row;
      scan   <= n_scan;
      in_adj <= n_adj;
      if (!n_adj && n_row == cfg_vsync_at && n_scan == '0) vs_cnt <= vs_w;
      else if (vs_cnt != '0) vs_cnt <= vs_cnt - 1'b1;
    end else begin
      col <= col + 1'b1;
    end
  end

  assign hsync   = ({1'b0, col} >= {1'b0, cfg_hsync_at}) && ({1'b0, col} < hs_end);
  assign vsync   = (vs_cnt != '0);
  assign disp_en = (col < cfg_hdisp) && (row < cfg_vdisp) && !in_adj;
  assign vblank  = (row >= cfg_vdisp) || in_adj;

  p_col_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (col < cfg_htotal) |=> (col == $past(col) + 1'b1));
  p_col_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (col == cfg_htotal) |=> (col == '0));
  p_no_hsync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sync_w[3:0] == 4'd0) |-> !hsync);
  p_scan_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_adj |-> (scan <= cfg_scan_max));
  p_frame_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_adj && line_end && adj_last) |=> (row == '0 && scan == '0));
  p_adj_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_adj) |-> (row == cfg_vtotal && scan == '0 && col == '0));
  p_vs_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> (row == cfg_vsync_at && scan == '0 && col == '0));
  p_de_vb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> !vblank);
endmodule

// File: tb/crt_raster_timer_tb.sv
`timescale 1ns/1ps
module crt_raster_timer_tb_top;
  logic clk = 0, rst_n = 0;
  logic [7:0] htotal, hdisp, hsat, syncw, vtotal, vdisp, vsat;
  logic [4:0] vadj, smax;
  logic [7:0] col, row;
  logic [4:0] scan;
  logic hsync, vsync, disp_en, vblank;
  int errors = 0, checks = 0, cycles = 0;
  int m_col, m_row, m_scan, m_adj, m_vs;

  always #2.5 clk = ~clk;

  crt_raster_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_htotal(htotal), .cfg_hdisp(hdisp),
    .cfg_hsync_at(hsat), .cfg_sync_w(syncw), .cfg_vtotal(vtotal),
    .cfg_vadjust(vadj), .cfg_vdisp(vdisp), .cfg_vsync_at(vsat),
    .cfg_scan_max(smax), .col(col), .row(row), .scan(scan),
    .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .vblank(vblank));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 20) $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic int vs_lines();
    return (syncw[7:4] == 0) ? 16 : int'(syncw[7:4]);
  endfunction

  task automatic model_step();
    int nr, ns, na;
    if (m_col >= htotal) begin
      m_col = 0; nr = m_row; ns = m_scan; na = m_adj;
      if (m_adj) begin
        if (m_scan + 1 >= vadj) begin nr = 0; ns = 0; na = 0; end else ns = m_scan + 1;
      end else if (m_scan >= smax) begin
        ns = 0;
        if (m_row >= vtotal) begin if (vadj == 0) nr = 0; else na = 1; end
        else nr = m_row + 1;
      end else ns = m_scan + 1;
      m_row = nr; m_scan = ns; m_adj = na;
      if (na == 0 && nr == vsat && ns == 0) m_vs = vs_lines();
      else if (m_vs != 0) m_vs--;
    end else m_col++;
  endtask

  task automatic compare();
    int he;
    he = int'(hsat) + int'(syncw[3:0]);
    chk("R1 col", col, m_col);
    chk("R2 hsync", hsync, (m_col >= hsat && m_col < he) ? 1 : 0);
    chk(m_adj ? "R5 scan" : "R3 scan", scan, m_scan);
    chk(m_adj ? "R5 row" : "R4 row", row, m_row);
    chk("R6 vsync", vsync, (m_vs != 0) ? 1 : 0);
    chk("R7 disp_en", disp_en, (m_col < hdisp && m_row < vdisp && !m_adj) ? 1 : 0);
    chk("R8 vblank", vblank, (m_row >= vdisp || m_adj) ? 1 : 0);
  endtask

  task automatic run_cfg(int frames);
    int lines, total;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 col", col, 0); chk("R9 row", row, 0);
    chk("R9 scan", scan, 0); chk("R9 vsync", vsync, 0);
    m_col = 0; m_row = 0; m_scan = 0; m_adj = 0; m_vs = 0;
    rst_n = 1;
    lines = (int'(vtotal) + 1) * (int'(smax) + 1) + int'(vadj);
    total = frames * lines * (int'(htotal) + 1) + 5;
    for (int i = 0; i < total; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic set_cfg(int ht, int hd, int hp, int sw, int vt, int va, int vd, int vp, int sm);
    htotal = 8'(ht); hdisp = 8'(hd); hsat = 8'(hp); syncw = 8'(sw);
    vtotal = 8'(vt); vadj = 5'(va); vdisp = 8'(vd); vsat = 8'(vp); smax = 5'(sm);
  endtask

  always @(posedge clk) cycles++;

  initial begin
    void'($urandom(32'h5eed));
    // R1/R2 wide line with the power-on style horizontal values
    set_cfg(126, 80, 102, 8'h49, 4, 2, 3, 3, 1); run_cfg(2);
    // R2 zero horizontal width; R6 zero vertical field means 16 lines
    set_cfg(9, 5, 6, 8'h00, 5, 0, 4, 1, 3); run_cfg(2);
    // R4 no extra lines; R5 maximum extra lines
    set_cfg(4, 2, 3, 8'h21, 2, 0, 2, 2, 2); run_cfg(2);
    set_cfg(4, 2, 3, 8'h31, 1, 31, 1, 0, 0); run_cfg(2);
    // R6 sync at row 0, R7/R8 nothing displayed
    set_cfg(5, 0, 0, 8'h1F, 3, 1, 0, 0, 1); run_cfg(2);
    for (int k = 0; k < 12; k++) begin
      int ht, vt;
      ht = 3 + int'($urandom_range(0, 17));
      vt = int'($urandom_range(0, 7));
      set_cfg(ht, $urandom_range(0, ht + 1), $urandom_range(0, ht), $urandom_range(0, 255),
              vt, $urandom_range(0, 5), $urandom_range(0, vt + 1), $urandom_range(0, vt),
              $urandom_range(0, 4));
      run_cfg(2);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule